// File: doc/BRIEF.md
# Dual-Edge Pin Capture Stage

This block conditions one group of input pins before the data reaches the core. It can pass the pins through with no register, register them on the rising system clock, or sample them on both edges of a source strobe. When it samples on the strobe, the two half-rate streams are moved onto the system clock. A selectable clock phase decides whether that move happens on the rising or the falling system clock edge. An optional two-to-one gearbox then collects two consecutive strobe periods and presents them side by side at half rate, with a one-cycle marker on each update.

All capture and transfer registers run in every mode, gated only by the capture enable. The mode input chooses what reaches the core outputs and whether the gearbox sequencer runs. Two asynchronous resets drive every register to a value set by a parameter: an active-high local reset and an active-low global reset.

Top module: `ddrin_capture`

## Requirements
- R1: With `mode` = 2'b00 (pass-through), `core_d0` follows `pin` combinationally. `core_d1`, `core_d2` and `core_d3` are zero and `core_vld` is 1.
- R2: With `mode` = 2'b01 (single rate), `core_d0` shows the value `pin` had at the previous rising edge of `clk_sys` on which `cap_en` was high. `core_d1` to `core_d3` are zero and `core_vld` is 1.
- R3: On each rising edge of `strobe` the pin value is captured into the early stream. On each falling edge of `strobe` it is captured into the late stream.
- R4: With `mode` = 2'b10 (dual rate) and `xfer_inv` = 0, both streams are re-registered on the rising `clk_sys` edge. `core_d0` shows the early stream and `core_d1` the late stream. `core_d2` and `core_d3` are zero and `core_vld` is 1.
- R5: With `xfer_inv` = 1, the transfer uses the falling `clk_sys` edge. Changing `xfer_inv` selects the other transfer pair at once.
- R6: With `mode` = 2'b11 (geared), the gearbox takes the transferred pair on each rising `clk_sys` edge. The first pair is held. On the second edge, `core_d0`/`core_d1` show the held (earlier) pair and `core_d2`/`core_d3` show the pair taken on that edge.
- R7: In geared mode, `core_vld` is high for exactly the one cycle after each gearbox update and is never high in two consecutive cycles.
- R8: Any cycle spent outside geared mode restarts the gearbox phase. The first geared edge after re-entry holds a pair and does not update the outputs.
- R9: While `cap_en` is low, every register holds its value and the gearbox does not advance. In geared mode `core_vld` is low.
- R10: While `loc_rst` is high, every register takes the value `{W{INIT_VAL}}` asynchronously and the gearbox phase and marker are cleared.
- R11: While `glob_rst_n` is low, the same asynchronous initialisation as R10 applies.
- R12: Capture and transfer registers run in every mode. Switching mode changes only the output selection and shows already-captured data on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| loc_rst | input | 1 | Local asynchronous reset, active high |
| glob_rst_n | input | 1 | Global asynchronous reset, active low |
| cap_en | input | 1 | Capture enable for all registers |
| mode | input | 2 | 00 pass-through, 01 single rate, 10 dual rate, 11 geared |
| xfer_inv | input | 1 | 1 selects the falling system clock edge for the dual-rate transfer |
| strobe | input | 1 | Source strobe for dual-edge sampling |
| pin | input | W | Pin data |
| core_d0 | output | W | Pass-through / single rate / early stream / earlier early sample |
| core_d1 | output | W | Late stream / earlier late sample |
| core_d2 | output | W | Later early sample (geared only) |
| core_d3 | output | W | Later late sample (geared only) |
| core_vld | output | 1 | Update marker in geared mode, 1 otherwise |

## Verification
In the falling-edge transfer mode the late stream pairs with the early sample of the following strobe period. A design that pairs the samples the same way for both polarities would show wrong `core_d1` values as soon as `xfer_inv` toggles. The gearbox is checked across a mode excursion: a phase bit that survives leaving geared mode would move the update one cycle and mix pairs from different periods. Holding `cap_en` low in dual-rate and geared modes exposes any register that still advances on an edge or a marker that stays asserted. Switching directly between modes without a warm-up catches a design that clocks its capture registers only in the active mode.

// File: rtl/ddrin_pkg.sv
`timescale 1ns/1ps
package ddrin_pkg;
   typedef enum logic [1:0] {
      MODE_PASS = 2'b00,
      MODE_SDR  = 2'b01,
      MODE_DDR  = 2'b10,
      MODE_GEAR = 2'b11
   } cap_mode_e;
endpackage

// File: rtl/ddrin_cap_reg.sv
`timescale 1ns/1ps
// Enabled register with asynchronous init; the active edge is a parameter.
module ddrin_cap_reg #(
   parameter int   W         = 2,
   parameter logic INIT_VAL  = 1'b0,
   parameter bit   FALL_EDGE = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] INIT_VEC = {W{INIT_VAL}};

   generate
      if (W < 1) begin : g_bad_width
         $error("ddrin_cap_reg: W must be at least 1");
      end
      if (FALL_EDGE) begin : g_fall
         always_ff @(negedge clk or posedge rst) begin
            if (rst)     q <= INIT_VEC;
            else if (ce) q <= d;
         end
      end else begin : g_rise
         always_ff @(posedge clk or posedge rst) begin
            if (rst)     q <= INIT_VEC;
            else if (ce) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/ddrin_xfer.sv
`timescale 1ns/1ps
// Moves the early/late stream pair onto the system clock on both edges;
// the polarity control picks which pair is presented.
module ddrin_xfer #(
   parameter int   W        = 2,
   parameter logic INIT_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic         inv,
   input  logic [W-1:0] s_early,
   input  logic [W-1:0] s_late,
   output logic [W-1:0] x_early,
   output logic [W-1:0] x_late
);
   localparam int PW = 2 * W;

   logic [PW-1:0] pair_q [2];

   generate
      for (genvar e = 0; e < 2; e++) begin : g_edge
         ddrin_cap_reg #(
            .W        (PW),
            .INIT_VAL (INIT_VAL),
            .FALL_EDGE(e == 1)
         ) u_pair (
            .clk(clk),
            .rst(rst),
            .ce (ce),
            .d  ({s_late, s_early}),
            .q  (pair_q[e])
         );
      end
   endgenerate

   assign {x_late, x_early} = inv ? pair_q[1] : pair_q[0];
endmodule

// File: rtl/ddrin_gearbox.sv
`timescale 1ns/1ps
// Two-to-one gearbox: holds one pair, then presents held and new pair together.
module ddrin_gearbox #(
   parameter int   W        = 2,
   parameter logic INIT_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic         en,
   input  logic [W-1:0] din_e,
   input  logic [W-1:0] din_l,
   output logic [W-1:0] old_e,
   output logic [W-1:0] old_l,
   output logic [W-1:0] new_e,
   output logic [W-1:0] new_l,
   output logic         upd
);
   localparam int            PW        = 2 * W;
   localparam logic [PW-1:0] PAIR_INIT = {PW{INIT_VAL}};

   logic          phase;
   logic [PW-1:0] hold_q;
   logic [PW-1:0] old_q;
   logic [PW-1:0] new_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         phase  <= 1'b0;
         upd    <= 1'b0;
         hold_q <= PAIR_INIT;
         old_q  <= PAIR_INIT;
         new_q  <= PAIR_INIT;
      end else if (!en) begin
         phase <= 1'b0;
         upd   <= 1'b0;
      end else if (ce) begin
         if (!phase) begin
            hold_q <= {din_l, din_e};
         end else begin
            old_q <= hold_q;
            new_q <= {din_l, din_e};
         end
         phase <= ~phase;
         upd   <= phase;
      end else begin
         upd <= 1'b0;
      end
   end

   assign {old_l, old_e} = old_q;
   assign {new_l, new_e} = new_q;
endmodule

// File: rtl/ddrin_capture.sv
`timescale 1ns/1ps
module ddrin_capture
   import ddrin_pkg::*;
#(
   parameter int   W        = 2,
   parameter logic INIT_VAL = 1'b0
) (
   input  logic         clk_sys,
   input  logic         loc_rst,
   input  logic         glob_rst_n,
   input  logic         cap_en,
   input  logic [1:0]   mode,
   input  logic         xfer_inv,
   input  logic         strobe,
   input  logic [W-1:0] pin,
   output logic [W-1:0] core_d0,
   output logic [W-1:0] core_d1,
   output logic [W-1:0] core_d2,
   output logic [W-1:0] core_d3,
   output logic         core_vld
);
   generate
      if (W < 1) begin : g_bad_width
         $error("ddrin_capture: W must be at least 1");
      end
   endgenerate

   cap_mode_e    sel;
   logic         rst_any;
   logic [W-1:0] sdr_q;
   logic [W-1:0] s_early;
   logic [W-1:0] s_late;
   logic [W-1:0] x_early;
   logic [W-1:0] x_late;
   logic [W-1:0] g_old_e;
   logic [W-1:0] g_old_l;
   logic [W-1:0] g_new_e;
   logic [W-1:0] g_new_l;
   logic         g_upd;

   assign sel     = cap_mode_e'(mode);
   assign rst_any = loc_rst | ~glob_rst_n;

   ddrin_cap_reg #(.W(W), .INIT_VAL(INIT_VAL), .FALL_EDGE(1'b0)) u_sdr (
      .clk(clk_sys), .rst(rst_any), .ce(cap_en), .d(pin), .q(sdr_q)
   );

   ddrin_cap_reg #(.W(W), .INIT_VAL(INIT_VAL), .FALL_EDGE(1'b0)) u_stb_rise (
      .clk(strobe), .rst(rst_any), .ce(cap_en), .d(pin), .q(s_early)
   );

   ddrin_cap_reg #(.W(W), .INIT_VAL(INIT_VAL), .FALL_EDGE(1'b1)) u_stb_fall (
      .clk(strobe), .rst(rst_any), .ce(cap_en), .d(pin), .q(s_late)
   );

   ddrin_xfer #(.W(W), .INIT_VAL(INIT_VAL)) u_xfer (
      .clk    (clk_sys),
      .rst    (rst_any),
      .ce     (cap_en),
      .inv    (xfer_inv),
      .s_early(s_early),
      .s_late (s_late),
      .x_early(x_early),
      .x_late (x_late)
   );

   ddrin_gearbox #(.W(W), .INIT_VAL(INIT_VAL)) u_gear (
      .clk  (clk_sys),
      .rst  (rst_any),
      .ce   (cap_en),
      .en   (sel == MODE_GEAR),
      .din_e(x_early),
      .din_l(x_late),
      .old_e(g_old_e),
      .old_l(g_old_l),
      .new_e(g_new_e),
      .new_l(g_new_l),
      .upd  (g_upd)
   );

   always_comb begin
      core_d0  = '0;
      core_d1  = '0;
      core_d2  = '0;
      core_d3  = '0;
      core_vld = 1'b1;
      case (sel)
         MODE_PASS: core_d0 = pin;
         MODE_SDR:  core_d0 = sdr_q;
         MODE_DDR: begin
            core_d0 = x_early;
            core_d1 = x_late;
         end
         MODE_GEAR: begin
            core_d0  = g_old_e;
            core_d1  = g_old_l;
            core_d2  = g_new_e;
            core_d3  = g_new_l;
            core_vld = g_upd;
         end
         default: core_vld = 1'b1;
      endcase
   end
endmodule

// File: rtl/ddrin_capture_chk.sv
`timescale 1ns/1ps
module ddrin_capture_chk #(
   parameter int   W        = 2,
   parameter logic INIT_VAL = 1'b0
) (
   input logic         clk_sys,
   input logic         loc_rst,
   input logic         glob_rst_n,
   input logic         cap_en,
   input logic [1:0]   mode,
   input logic         xfer_inv,
   input logic [W-1:0] pin,
   input logic [W-1:0] core_d0,
   input logic [W-1:0] core_d1,
   input logic         core_vld
);
   localparam logic [W-1:0] INIT_VEC = {W{INIT_VAL}};

   logic rst_any;
   logic warm;

   assign rst_any = loc_rst | ~glob_rst_n;

   always_ff @(posedge clk_sys or posedge rst_any) begin
      if (rst_any) warm <= 1'b0;
      else         warm <= 1'b1;
   end

   // R1
   assert_pass_R1: assert property (@(posedge clk_sys) disable iff (rst_any)
      (mode == 2'b00) |-> (core_d0 == pin && core_d1 == '0));

   // R2
   assert_sdr_R2: assert property (@(posedge clk_sys) disable iff (rst_any)
      (warm && mode == 2'b01 && $past(cap_en)) |-> (core_d0 == $past(pin)));

   // R7
   assert_single_pulse_R7: assert property (@(posedge clk_sys) disable iff (rst_any)
      (warm && mode == 2'b11 && core_vld) |=> (!core_vld || mode != 2'b11));

   // R9
   assert_hold_R9: assert property (@(posedge clk_sys) disable iff (rst_any)
      (warm && !$past(cap_en) && mode == 2'b10 && $past(mode) == 2'b10
       && !xfer_inv && !$past(xfer_inv))
      |-> ($stable(core_d0) && $stable(core_d1)));

   // R10
   assert_lsr_init_R10: assert property (@(posedge clk_sys)
      (loc_rst && mode != 2'b00) |-> (core_d0 == INIT_VEC));

   // R11
   assert_gsr_init_R11: assert property (@(posedge clk_sys)
      (!glob_rst_n && mode != 2'b00) |-> (core_d0 == INIT_VEC));
endmodule

bind ddrin_capture ddrin_capture_chk #(.W(W), .INIT_VAL(INIT_VAL)) u_chk (
   .clk_sys   (clk_sys),
   .loc_rst   (loc_rst),
   .glob_rst_n(glob_rst_n),
   .cap_en    (cap_en),
   .mode      (mode),
   .xfer_inv  (xfer_inv),
   .pin       (pin),
   .core_d0   (core_d0),
   .core_d1   (core_d1),
   .core_vld  (core_vld)
);

// File: tb/ddrin_capture_tb.sv
`timescale 1ns/1ps
module ddrin_capture_tb;
   localparam int             W    = 2;
   localparam logic           INIT = 1'b1;
   localparam logic [W-1:0]   IV   = {W{INIT}};

   logic         clk_sys = 1'b0;
   logic         strobe  = 1'b0;
   logic         loc_rst = 1'b0;
   logic         glob_rst_n = 1'b0;
   logic         cap_en = 1'b1;
   logic [1:0]   mode = 2'b10;
   logic         xfer_inv = 1'b0;
   logic [W-1:0] pin = '0;
   logic [W-1:0] core_d0, core_d1, core_d2, core_d3;
   logic         core_vld;

   ddrin_capture #(.W(W), .INIT_VAL(INIT)) u_dut (
      .clk_sys(clk_sys), .loc_rst(loc_rst), .glob_rst_n(glob_rst_n),
      .cap_en(cap_en), .mode(mode), .xfer_inv(xfer_inv), .strobe(strobe),
      .pin(pin), .core_d0(core_d0), .core_d1(core_d1), .core_d2(core_d2),
      .core_d3(core_d3), .core_vld(core_vld)
   );

   // 125 MHz system clock; strobe trails it by a quarter period
   initial begin
      forever begin
         #2 clk_sys = 1'b1;
         #2 strobe  = 1'b1;
         #2 clk_sys = 1'b0;
         #2 strobe  = 1'b0;
      end
   end

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // applied control values and next ones
   logic [1:0] cur_mode = 2'b10, nx_mode = 2'b10;
   logic cur_inv = 1'b0, nx_inv = 1'b0;
   logic cur_en = 1'b1, nx_en = 1'b1;
   logic cur_lrst = 1'b0, nx_lrst = 1'b0;
   logic cur_grn = 1'b0, nx_grn = 1'b0;
   logic [W-1:0] a1 = '0, b1 = '0;

   // reference state
   logic [W-1:0] m_se, m_sl, m_pe, m_pl, m_ne, m_nl, m_sdr;
   logic [W-1:0] m_he, m_hl, m_oe, m_ol, m_ve, m_vl, g_e, g_l;
   logic m_ph, m_upd;

   task automatic model_init();
      m_se = IV; m_sl = IV; m_pe = IV; m_pl = IV; m_ne = IV; m_nl = IV;
      m_sdr = IV; m_he = IV; m_hl = IV; m_oe = IV; m_ol = IV;
      m_ve = IV; m_vl = IV; m_ph = 1'b0; m_upd = 1'b0;
   endtask

   // events of one period: strobe rise, clk fall, strobe fall, clk rise
   task automatic model_period();
      if (cur_en) begin
         m_se = a1;
         m_ne = m_se; m_nl = m_sl;
         m_sl = b1;
         g_e = cur_inv ? m_ne : m_pe;
         g_l = cur_inv ? m_nl : m_pl;
         m_pe = m_se; m_pl = m_sl;
         m_sdr = b1;
      end else begin
         g_e = cur_inv ? m_ne : m_pe;
         g_l = cur_inv ? m_nl : m_pl;
      end
      if (cur_mode != 2'b11) begin
         m_ph = 1'b0; m_upd = 1'b0;
      end else if (cur_en) begin
         if (!m_ph) begin
            m_he = g_e; m_hl = g_l;
         end else begin
            m_oe = m_he; m_ol = m_hl; m_ve = g_e; m_vl = g_l;
         end
         m_upd = m_ph;
         m_ph = ~m_ph;
      end else begin
         m_upd = 1'b0;
      end
   endtask

   task automatic check_out(input string tag);
      logic [4*W:0] exp_v, act_v;
      case (cur_mode)
         2'b00: exp_v = {pin, {W{1'b0}}, {W{1'b0}}, {W{1'b0}}, 1'b1};
         2'b01: exp_v = {m_sdr, {W{1'b0}}, {W{1'b0}}, {W{1'b0}}, 1'b1};
         2'b10: exp_v = {cur_inv ? m_ne : m_pe, cur_inv ? m_nl : m_pl,
                         {W{1'b0}}, {W{1'b0}}, 1'b1};
         default: exp_v = {m_oe, m_ol, m_ve, m_vl, m_upd};
      endcase
      act_v = {core_d0, core_d1, core_d2, core_d3, core_vld};
      n_tests++;
      if (act_v !== exp_v) begin
         n_fail++;
         $display("FAIL %s: mode=%b got %h expected %h", tag, cur_mode, act_v, exp_v);
      end
   endtask

   task automatic step(input logic [W-1:0] pa, input logic [W-1:0] pb, input string tag);
      @(posedge clk_sys);
      #1;
      if (cur_lrst || !cur_grn) model_init();
      else                      model_period();
      check_out(tag);
      mode = nx_mode; xfer_inv = nx_inv; cap_en = nx_en;
      loc_rst = nx_lrst; glob_rst_n = nx_grn;
      cur_mode = nx_mode; cur_inv = nx_inv; cur_en = nx_en;
      cur_lrst = nx_lrst; cur_grn = nx_grn;
      pin = pa; a1 = pa;
      if (cur_lrst || !cur_grn) begin
         model_init();
         #0.5 check_out(tag);
         #3.5;
      end else if (cur_mode == 2'b00) begin
         #0.5 check_out(tag);
         #3.5;
      end else begin
         #4;
      end
      pin = pb; b1 = pb;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      model_init();
      // R11: global reset held from time zero
      step(2'b00, 2'b01, "R11");
      step(2'b10, 2'b01, "R11");
      nx_grn = 1'b1;
      step(2'b01, 2'b10, "R11");
      // R3 / R4: rising-edge transfer over all early/late patterns
      for (int i = 0; i < 16; i++) step(i[1:0], i[3:2], "R3");
      for (int i = 15; i >= 0; i--) step(i[3:2], i[1:0], "R4");
      // R5: falling-edge transfer, then toggling every period
      nx_inv = 1'b1;
      for (int i = 0; i < 16; i++) step(i[1:0], ~i[3:2], "R5");
      for (int i = 0; i < 16; i++) begin
         nx_inv = i[0];
         step(i[3:2], i[1:0], "R5");
      end
      nx_inv = 1'b0;
      // R12 then R2: switch straight to single rate
      nx_mode = 2'b01;
      step(2'b11, 2'b00, "R12");
      step(2'b01, 2'b10, "R12");
      for (int i = 0; i < 16; i++) step(i[1:0], i[3:2], "R2");
      // R1: pass-through
      nx_mode = 2'b00;
      for (int i = 0; i < 16; i++) step(i[3:2], i[1:0], "R1");
      // R6 / R7: geared, both transfer polarities
      nx_mode = 2'b11;
      for (int i = 0; i < 20; i++) step(i[1:0], i[3:2] ^ 2'b01, "R6");
      nx_inv = 1'b1;
      for (int i = 0; i < 20; i++) step(i[3:2], i[1:0] ^ 2'b10, "R7");
      nx_inv = 1'b0;
      // R8: odd number of geared periods, one period out, back in
      step(2'b11, 2'b01, "R8");
      nx_mode = 2'b10;
      step(2'b10, 2'b00, "R8");
      nx_mode = 2'b11;
      for (int i = 0; i < 7; i++) step(i[1:0], ~i[1:0], "R8");
      // R9: enable low in dual rate, then in geared mode
      nx_mode = 2'b10;
      step(2'b01, 2'b10, "R9");
      nx_en = 1'b0;
      for (int i = 0; i < 5; i++) step(i[1:0], ~i[1:0], "R9");
      nx_en = 1'b1;
      step(2'b00, 2'b11, "R9");
      nx_mode = 2'b11;
      for (int i = 0; i < 3; i++) step(i[1:0], 2'b10, "R9");
      nx_en = 1'b0;
      for (int i = 0; i < 4; i++) step(~i[1:0], i[1:0], "R9");
      nx_en = 1'b1;
      for (int i = 0; i < 4; i++) step(i[1:0], 2'b01, "R9");
      // R10: local reset pulse in geared mode
      nx_lrst = 1'b1;
      step(2'b00, 2'b00, "R10");
      nx_lrst = 1'b0;
      step(2'b01, 2'b10, "R10");
      for (int i = 0; i < 6; i++) step(i[1:0], ~i[1:0], "R10");
      // R11: global reset pulse in single-rate mode
      nx_mode = 2'b01;
      step(2'b00, 2'b00, "R11");
      nx_grn = 1'b0;
      step(2'b00, 2'b00, "R11");
      nx_grn = 1'b1;
      step(2'b10, 2'b01, "R11");
      for (int i = 0; i < 4; i++) step(i[1:0], i[1:0], "R11");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule